// File: doc/BRIEF.md
# Sample rate and clock ratio detector

This block watches the frame clock and bit clock of a serial audio stream, sampled in the system clock domain, and works out which speed class the stream belongs to. For every frame-clock period it counts three quantities: system clock cycles, rising bit-clock edges, and pulses of a strobe that runs at a known reference frequency (`REF_HZ`). The reference count gives the absolute frame rate. The system-clock count gives the clock ratio. Together they separate ratios that more than one speed class allows, such as 128 or 256.

Each completed frame is classified as one of three speed classes with a ratio code, or as illegal. A hysteresis filter turns the per-frame results into a steady, locked report. If the frame clock stops, a timeout clears the lock.

Top module: `rate_ratio_detector`

## Requirements
- R1: `mode_o` encodes the locked speed class as 1 = single (8 to 50 kHz), 2 = double (84 to 100 kHz), 3 = quad (167 to 200 kHz), and 0 = none. The class comes from the reference ticks counted per frame, compared with windows derived from `REF_HZ`. A rate outside every window is illegal.
- R2: `ratio_o` codes the system-clock cycles per frame as 0 = 128, 1 = 192, 2 = 256, 3 = 384, 4 = 512, 5 = 768, 6 = 1024.
- R3: The legal ratios depend on the class. Single allows 256, 384, 512, 768 and 1024. Double allows 128, 192, 256, 384 and 512. Quad allows 128, 192 and 256. Any other combination of class and ratio makes the frame illegal.
- R4: A measured period counts as a ratio when it lies within ±2 cycles of that ratio. At 3 cycles away the frame is illegal.
- R5: A frame is legal only if it holds 64 ±1 rising bit-clock edges.
- R6: `locked_o` rises only after 8 consecutive legal frames with the same classification. It is still low after fewer.
- R7: While locked, one mismatching frame leaves the lock in place. Two consecutive mismatching frames drop `locked_o`.
- R8: If no frame-clock rising edge arrives within `TIMEOUT_CYCLES` system cycles, `locked_o`, `valid_o`, `mode_o` and `ratio_o` all clear. Lock returns once the stream resumes.
- R9: `valid_o` shows whether the most recently completed frame was legal.
- R10: During and just after reset, all outputs are 0.
- R11: `mode_o` and `ratio_o` are 0 whenever the block is unlocked, and they do not change while the lock is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all counting runs on it |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_clk_i | input | 1 | Frame (left/right) clock, synchronized inside |
| bit_clk_i | input | 1 | Bit clock, synchronized inside |
| ref_tick_i | input | 1 | One-cycle strobe at the reference frequency |
| mode_o | output | 2 | Locked speed class code (R1) |
| ratio_o | output | 3 | Locked ratio code (R2) |
| valid_o | output | 1 | Last frame was legal |
| locked_o | output | 1 | Classification is held steady |

## Verification
The hardest states to reach from the ports are a locked block that sees exactly one bad frame, and one that sees exactly two bad frames, while the frame-clock edges stay regular. Changing the ratio at a frame boundary corrupts two measurement windows, not one.

The stimulus therefore holds the frame clock steady and suppresses the bit clock only over the second half of one or two frames. This spoils exactly one or two measurements. A bench-side counter of falling lock edges then shows whether the lock survived. Rates that share a ratio between classes are reached by changing the reference-strobe spacing while the system-clock ratio stays fixed.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  typedef enum logic [1:0] {
    MODE_NONE   = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_DOUBLE = 2'd2,
    MODE_QUAD   = 2'd3
  } speed_mode_e;

  localparam int unsigned NUM_RATIOS = 7;

  localparam int unsigned SGL_MIN_HZ = 8000;
  localparam int unsigned SGL_MAX_HZ = 50000;
  localparam int unsigned DBL_MIN_HZ = 84000;
  localparam int unsigned DBL_MAX_HZ = 100000;
  localparam int unsigned QAD_MIN_HZ = 167000;
  localparam int unsigned QAD_MAX_HZ = 200000;

  typedef struct packed {
    logic        ok;
    speed_mode_e mode;
    logic [2:0]  ratio;
  } frame_class_t;

  // even codes: 128 * 2^(k/2); odd codes: 192 * 2^(k/2)
  function automatic int unsigned ratio_of_code(int unsigned code);
    return (code % 2 == 0) ? (128 << (code / 2)) : (192 << (code / 2));
  endfunction

  function automatic logic [7:0] allowed_mask(speed_mode_e m);
    case (m)
      MODE_SINGLE: return 8'b0111_1100;
      MODE_DOUBLE: return 8'b0001_1111;
      MODE_QUAD:   return 8'b0000_0111;
      default:     return 8'b0000_0000;
    endcase
  endfunction
endpackage

// File: rtl/rrc_edge_sync.sv
module rrc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/rrc_frame_meter.sv
module rrc_frame_meter #(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned TIMEOUT = 2048
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_rise_i,
  input  logic             bit_rise_i,
  input  logic             ref_tick_i,
  output logic             done_o,
  output logic [CNT_W-1:0] sys_len_o,
  output logic [CNT_W-1:0] ref_len_o,
  output logic [CNT_W-1:0] bit_len_o,
  output logic             timeout_o
);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT - 1);
  localparam logic [CNT_W-1:0] TMO_CAP  = CNT_W'(TIMEOUT);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [CNT_W-1:0] sys_cnt_q, ref_cnt_q, bit_cnt_q;
  logic             primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_cnt_q <= '0;
      ref_cnt_q <= '0;
      bit_cnt_q <= '0;
      primed_q  <= 1'b0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      sys_len_o <= '0;
      ref_len_o <= '0;
      bit_len_o <= '0;
    end else begin
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      if (frame_rise_i) begin
        done_o    <= primed_q;
        sys_len_o <= sys_cnt_q + CNT_W'(1);
        ref_len_o <= ref_cnt_q;
        bit_len_o <= bit_cnt_q;
        primed_q  <= 1'b1;
        sys_cnt_q <= '0;
        ref_cnt_q <= CNT_W'(ref_tick_i);
        bit_cnt_q <= CNT_W'(bit_rise_i);
      end else begin
        if (sys_cnt_q == TMO_LAST) begin
          timeout_o <= 1'b1;
          primed_q  <= 1'b0;
        end
        if (sys_cnt_q != TMO_CAP) sys_cnt_q <= sys_cnt_q + CNT_W'(1);
        if (ref_tick_i && ref_cnt_q != CNT_MAX) ref_cnt_q <= ref_cnt_q + CNT_W'(1);
        if (bit_rise_i && bit_cnt_q != CNT_MAX) bit_cnt_q <= bit_cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/rrc_classifier.sv
module rrc_classifier
  import rrc_pkg::*;
#(
  parameter int unsigned CNT_W          = 12,
  parameter int unsigned REF_HZ         = 6144000,
  parameter int unsigned RATIO_TOL      = 2,
  parameter int unsigned BITS_PER_FRAME = 64,
  parameter int unsigned BIT_TOL        = 1
) (
  input  logic [CNT_W-1:0] sys_len_i,
  input  logic [CNT_W-1:0] ref_len_i,
  input  logic [CNT_W-1:0] bit_len_i,
  output frame_class_t     class_o
);
  localparam logic [CNT_W-1:0] SGL_LO = CNT_W'((REF_HZ + SGL_MAX_HZ - 1) / SGL_MAX_HZ);
  localparam logic [CNT_W-1:0] SGL_HI = CNT_W'(REF_HZ / SGL_MIN_HZ);
  localparam logic [CNT_W-1:0] DBL_LO = CNT_W'((REF_HZ + DBL_MAX_HZ - 1) / DBL_MAX_HZ);
  localparam logic [CNT_W-1:0] DBL_HI = CNT_W'(REF_HZ / DBL_MIN_HZ);
  localparam logic [CNT_W-1:0] QAD_LO = CNT_W'((REF_HZ + QAD_MAX_HZ - 1) / QAD_MAX_HZ);
  localparam logic [CNT_W-1:0] QAD_HI = CNT_W'(REF_HZ / QAD_MIN_HZ);
  localparam logic [CNT_W-1:0] BIT_LO = CNT_W'(BITS_PER_FRAME - BIT_TOL);
  localparam logic [CNT_W-1:0] BIT_HI = CNT_W'(BITS_PER_FRAME + BIT_TOL);

  logic [NUM_RATIOS-1:0] hit;

  for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_ratio
    localparam logic [CNT_W-1:0] LO = CNT_W'(ratio_of_code(i) - RATIO_TOL);
    localparam logic [CNT_W-1:0] HI = CNT_W'(ratio_of_code(i) + RATIO_TOL);
    assign hit[i] = (sys_len_i >= LO) && (sys_len_i <= HI);
  end

  speed_mode_e mode;
  logic [2:0]  code;
  logic [7:0]  mask;
  logic        bits_ok;

  always_comb begin
    if      (ref_len_i >= QAD_LO && ref_len_i <= QAD_HI) mode = MODE_QUAD;
    else if (ref_len_i >= DBL_LO && ref_len_i <= DBL_HI) mode = MODE_DOUBLE;
    else if (ref_len_i >= SGL_LO && ref_len_i <= SGL_HI) mode = MODE_SINGLE;
    else                                                 mode = MODE_NONE;

    code = 3'd0;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (hit[i]) code = 3'(i);
    end

    mask    = allowed_mask(mode);
    bits_ok = (bit_len_i >= BIT_LO) && (bit_len_i <= BIT_HI);

    class_o = '0;
    if (mode != MODE_NONE && |hit && mask[code] && bits_ok) begin
      class_o.ok    = 1'b1;
      class_o.mode  = mode;
      class_o.ratio = code;
    end
  end
endmodule

// File: rtl/rrc_lock_filter.sv
module rrc_lock_filter
  import rrc_pkg::*;
#(
  parameter int unsigned LOCK_FRAMES = 8,
  parameter int unsigned MISS_FRAMES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         done_i,
  input  frame_class_t class_i,
  input  logic         timeout_i,
  output logic         locked_o,
  output logic         valid_o,
  output frame_class_t held_o
);
  localparam int unsigned CW = $clog2(LOCK_FRAMES + 1);
  localparam int unsigned MW = $clog2(MISS_FRAMES + 1);
  localparam logic [CW-1:0] LOCK_AT  = CW'(LOCK_FRAMES);
  localparam logic [MW-1:0] MISS_END = MW'(MISS_FRAMES - 1);

  frame_class_t   cand_q;
  logic [CW-1:0]  run_q, run_next;
  logic [MW-1:0]  miss_q;

  always_comb begin
    if (class_i.ok && class_i == cand_q && run_q != '0) run_next = run_q + CW'(1);
    else                                                run_next = CW'(class_i.ok);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q   <= '0;
      run_q    <= '0;
      miss_q   <= '0;
      locked_o <= 1'b0;
      valid_o  <= 1'b0;
      held_o   <= '0;
    end else if (timeout_i) begin
      cand_q   <= '0;
      run_q    <= '0;
      miss_q   <= '0;
      locked_o <= 1'b0;
      valid_o  <= 1'b0;
      held_o   <= '0;
    end else if (done_i) begin
      valid_o <= class_i.ok;
      if (!locked_o) begin
        cand_q <= class_i;
        if (run_next == LOCK_AT) begin
          locked_o <= 1'b1;
          held_o   <= class_i;
          run_q    <= '0;
          miss_q   <= '0;
        end else begin
          run_q <= run_next;
        end
      end else if (class_i == held_o) begin
        miss_q <= '0;
      end else if (miss_q == MISS_END) begin
        locked_o <= 1'b0;
        held_o   <= '0;
        miss_q   <= '0;
        cand_q   <= class_i;
        run_q    <= CW'(class_i.ok);
      end else begin
        miss_q <= miss_q + MW'(1);
      end
    end
  end
endmodule

// File: rtl/rate_ratio_detector.sv
module rate_ratio_detector
  import rrc_pkg::*;
#(
  parameter int unsigned REF_HZ         = 6144000,
  parameter int unsigned TIMEOUT_CYCLES = 2048,
  parameter int unsigned RATIO_TOL      = 2,
  parameter int unsigned BITS_PER_FRAME = 64,
  parameter int unsigned BIT_TOL        = 1,
  parameter int unsigned LOCK_FRAMES    = 8,
  parameter int unsigned MISS_FRAMES    = 2,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_clk_i,
  input  logic       bit_clk_i,
  input  logic       ref_tick_i,
  output logic [1:0] mode_o,
  output logic [2:0] ratio_o,
  output logic       valid_o,
  output logic       locked_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYCLES + 2);

  logic [1:0] raw_clk, rise;
  assign raw_clk = {bit_clk_i, frame_clk_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    rrc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(raw_clk[g]),
      .rise_o (rise[g])
    );
  end

  logic             meas_done, meas_timeout;
  logic [CNT_W-1:0] sys_len, ref_len, bit_len;

  rrc_frame_meter #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT_CYCLES)) u_meter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_rise_i(rise[0]),
    .bit_rise_i  (rise[1]),
    .ref_tick_i  (ref_tick_i),
    .done_o      (meas_done),
    .sys_len_o   (sys_len),
    .ref_len_o   (ref_len),
    .bit_len_o   (bit_len),
    .timeout_o   (meas_timeout)
  );

  frame_class_t cls, held;

  rrc_classifier #(
    .CNT_W(CNT_W), .REF_HZ(REF_HZ), .RATIO_TOL(RATIO_TOL),
    .BITS_PER_FRAME(BITS_PER_FRAME), .BIT_TOL(BIT_TOL)
  ) u_class (
    .sys_len_i(sys_len),
    .ref_len_i(ref_len),
    .bit_len_i(bit_len),
    .class_o  (cls)
  );

  rrc_lock_filter #(.LOCK_FRAMES(LOCK_FRAMES), .MISS_FRAMES(MISS_FRAMES)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (meas_done),
    .class_i  (cls),
    .timeout_i(meas_timeout),
    .locked_o (locked_o),
    .valid_o  (valid_o),
    .held_o   (held)
  );

  assign mode_o  = held.mode;
  assign ratio_o = held.ratio;
endmodule

// File: rtl/rrc_checker.sv
module rrc_checker
  import rrc_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic [2:0] ratio_i,
  input logic       valid_i,
  input logic       locked_i,
  input logic       timeout_i
);
  logic [7:0] legal;
  assign legal = allowed_mask(speed_mode_e'(mode_i));

  AST_UNLOCKED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_i |-> (mode_i == 2'd0 && ratio_i == 3'd0)); // R11
  AST_LOCK_HAS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i |-> mode_i != 2'd0); // R1
  AST_LOCKED_RATIO_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i |-> legal[ratio_i]); // R3
  AST_HELD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_i && $past(locked_i)) |-> ($stable(mode_i) && $stable(ratio_i))); // R11
  AST_LOCK_ON_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_i) |-> valid_i); // R6
  AST_TIMEOUT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_i |=> (!locked_i && !valid_i)); // R8
endmodule

bind rate_ratio_detector rrc_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_o),
  .ratio_i  (ratio_o),
  .valid_i  (valid_o),
  .locked_i (locked_o),
  .timeout_i(meas_timeout)
);

// File: tb/tb_rate_ratio_detector.sv
`timescale 1ns/1ps
module tb_rate_ratio_detector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_clk = 1'b0, bit_clk = 1'b0, ref_tick = 1'b0;
  logic [1:0] mode;
  logic [2:0] ratio;
  logic valid, locked;

  always #2 clk = ~clk;

  rate_ratio_detector dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_clk_i(frame_clk), .bit_clk_i(bit_clk),
    .ref_tick_i(ref_tick), .mode_o(mode), .ratio_o(ratio), .valid_o(valid), .locked_o(locked)
  );

  typedef struct {
    logic [1:0] mode;
    logic [2:0] ratio;
    logic       valid;
    logic       locked;
    string      req;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0, fails = 0, drops = 0;
  int cfg_r = 256, cfg_k = 2, cur_r = 256, kill_n = 0;
  bit run = 1'b0, finished = 1'b0;

  // stimulus generator
  initial begin
    int p = 0, gcnt = 0, bp;
    bit kill_act = 1'b0;
    forever begin
      @(negedge clk);
      gcnt++;
      ref_tick = (gcnt % cfg_k) == 0;
      if (!run) begin
        frame_clk = 1'b0; bit_clk = 1'b0; p = 0; kill_act = 1'b0;
      end else begin
        if (p == 0) begin cur_r = cfg_r; kill_act = 1'b0; end
        bp = cur_r / 64;
        if (p == cur_r / 2 && kill_n > 0) begin kill_act = 1'b1; kill_n--; end
        frame_clk = (p >= cur_r / 2);
        bit_clk   = kill_act ? 1'b0 : ((p % bp) >= bp / 2);
        p = (p + 1 == cur_r) ? 0 : p + 1;
      end
    end
  end

  // lock drop counter
  initial begin
    logic prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !locked) drops++;
      prev = locked;
    end
  end

  // scoreboard monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        checks++;
        if (mode !== e.mode || ratio !== e.ratio || valid !== e.valid || locked !== e.locked) begin
          fails++;
          $display("FAIL %s: actual mode=%0d ratio=%0d valid=%0b locked=%0b expected mode=%0d ratio=%0d valid=%0b locked=%0b",
                   e.req, mode, ratio, valid, locked, e.mode, e.ratio, e.valid, e.locked);
        end
      end
    end
  end

  task automatic expect_out(logic [1:0] m, logic [2:0] r, logic v, logic l, string req);
    exp_t e;
    e.mode = m; e.ratio = r; e.valid = v; e.locked = l; e.req = req;
    sb_q.push_back(e);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_int(int actual, int expected, string req);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic set_cfg(int r, int k);
    cfg_r = r; cfg_k = k;
  endtask

  task automatic run_frames(int n);
    repeat (n * cfg_r) @(negedge clk);
  endtask

  initial begin
    int d0;
    repeat (5) @(negedge clk);
    expect_out(2'd0, 3'd0, 1'b0, 1'b0, "R10 in reset");
    rst_n = 1'b1;
    expect_out(2'd0, 3'd0, 1'b0, 1'b0, "R10 after reset");

    // single speed, 256, 48 kHz
    set_cfg(256, 2); run = 1'b1;
    run_frames(6);
    expect_out(2'd0, 3'd0, 1'b1, 1'b0, "R6 not locked after few frames");
    run_frames(10);
    expect_out(2'd1, 3'd2, 1'b1, 1'b1, "R6 R1 R2 R9 single 256");

    set_cfg(320, 2); run_frames(16);
    expect_out(2'd0, 3'd0, 1'b0, 1'b0, "R2 R9 unsupported ratio 320");

    set_cfg(258, 2); run_frames(16);
    expect_out(2'd1, 3'd2, 1'b1, 1'b1, "R4 tolerance +2 accepted");

    set_cfg(259, 2); run_frames(16);
    expect_out(2'd0, 3'd0, 1'b0, 1'b0, "R4 tolerance +3 rejected");

    set_cfg(128, 2); run_frames(16);
    expect_out(2'd2, 3'd0, 1'b1, 1'b1, "R1 double 128");

    set_cfg(128, 4); run_frames(16);
    expect_out(2'd3, 3'd0, 1'b1, 1'b1, "R1 quad 128");

    set_cfg(256, 4); run_frames(16);
    expect_out(2'd2, 3'd2, 1'b1, 1'b1, "R3 double 256");

    set_cfg(1024, 16); run_frames(12);
    expect_out(2'd0, 3'd0, 1'b0, 1'b0, "R3 double 1024 illegal");

    set_cfg(256, 3); run_frames(16);
    expect_out(2'd0, 3'd0, 1'b0, 1'b0, "R1 rate in gap");

    set_cfg(256, 2); run_frames(16);
    expect_out(2'd1, 3'd2, 1'b1, 1'b1, "R1 single relock");

    d0 = drops;
    kill_n = 1; run_frames(4);
    expect_out(2'd1, 3'd2, 1'b1, 1'b1, "R7 single bad frame keeps lock");
    check_int(drops, d0, "R7 no drop on single bad frame");

    kill_n = 2; run_frames(4);
    expect_out(2'd0, 3'd0, 1'b1, 1'b0, "R7 R5 two bad frames drop lock");
    check_int(drops, d0 + 1, "R7 one drop");
    run_frames(12);
    expect_out(2'd1, 3'd2, 1'b1, 1'b1, "R6 relock after bit fault");

    run = 1'b0;
    repeat (2500) @(negedge clk);
    expect_out(2'd0, 3'd0, 1'b0, 1'b0, "R8 timeout clears");

    run = 1'b1; run_frames(16);
    expect_out(2'd1, 3'd2, 1'b1, 1'b1, "R8 recovery after timeout");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule